// File: doc/BRIEF.md
# Bit-Slip Tolerant Frame Receiver

This block sits behind a byte-clocked serial deserializer whose byte boundaries need not line up with the bit stream the far end sent. It watches the incoming raw bytes for the frame's sync sequence at every one of the eight possible bit slips. Once the sequence is found, it rebuilds each later byte on the true boundary, writes the frame bytes out with their index, checks the trailing CRC, and reports either a good frame or a CRC error.

Frames on the line are an alternating 1010 preamble (0xAA bytes), the two sync bytes 0xD3 0x91, a two-byte header (a zero byte, then a length byte giving the total frame size in bytes: header, payload and CRC together), the payload, and a 16-bit CRC sent high byte first. When sync is found, a one-cycle strobe tells the signal-strength logic to capture its reading. A good frame is held as pending until the consumer acknowledges it. While a frame is pending, the line is ignored.

Top module: `sync_align_rx`

## Requirements
- R1: After synchronous reset, wr_en, rssi_strobe, pkt_ready and crc_err are all 0 and the block is searching for sync.
- R2: In search, if the three bytes before the newest raw byte are 0xAA, 0xD3, 0x91, sync is taken with no bit slip. rssi_strobe pulses and the newest raw byte is written unchanged at index 0 in the cycle after it was presented.
- R3: In search, if the four newest raw bytes (oldest first) equal bits [31+d:d] of the 48-bit value 0xAAAAAAD39100 for a slip d from 1 to 7, sync is taken with slip d. rssi_strobe pulses and nothing is written. Each later byte is rebuilt as bits [15-d:8-d] of {previous raw byte, current raw byte}.
- R4: Every byte accepted while receiving is written once, on the cycle after its in_valid edge, at consecutive indexes that start at 0.
- R5: The byte at index 1 is the frame length. A value below 4 or above BUF_DEPTH abandons the frame after that byte is written. The block returns to search, and no further bytes of that frame are written.
- R6: When the count of written bytes reaches the length, the CRC is checked. The running CRC (reflected polynomial 0x8408, preset 0xFFFF, one byte per step, each byte's low bit first) covers the low byte and then the high byte of (length − 2), followed by the payload bytes at indexes 2 to length−3. The CRC must equal {byte[length−2], byte[length−1]}. On a match, pkt_ready rises on the cycle the last byte is written.
- R7: On a CRC mismatch, crc_err pulses for one cycle, pkt_ready stays 0, and the block resumes searching at once.
- R8: While pkt_ready is 1, raw bytes produce no writes and no rssi_strobe. pkt_ready stays 1 until ack is seen, and clears on the cycle after it.
- R9: ack has no effect while no frame is pending.
- R10: Raw bytes that form no sync window produce no writes and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A raw byte is presented this cycle |
| in_byte | input | 8 | Raw byte from the deserializer |
| ack | input | 1 | Consumer has taken the pending frame |
| wr_en | output | 1 | A realigned frame byte is being written |
| wr_idx | output | $clog2(BUF_DEPTH) | Index of the written byte within the frame |
| wr_data | output | 8 | Realigned frame byte |
| rssi_strobe | output | 1 | One-cycle pulse when sync is taken |
| pkt_ready | output | 1 | A frame with a good CRC is pending |
| crc_err | output | 1 | One-cycle pulse on CRC mismatch |

## Verification
The bench sends frames at all eight bit slips. A realigner that shifted the wrong way, or that had its slip mapping off by one, would write scrambled bytes, and sync would never be found for the slips whose pattern was wrong. It drives length bytes of 0, 3, BUF_DEPTH+1 and over 128, and also exactly BUF_DEPTH. A wrong bound would either stall in receive or throw away a legal maximum frame. It corrupts CRCs, feeds a complete frame while another is pending, and pulses ack during search. A block that seeded the CRC with the wrong count, or that listened while holding a frame, would flag good frames as bad or overwrite the pending one.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int HDR_BYTES = 2;
    localparam int CRC_BYTES = 2;
    localparam int MIN_FRAME = HDR_BYTES + CRC_BYTES;

    // Preamble tail, sync pair and the zero header byte, as sent on the line.
    localparam logic [47:0] SYNC_TRAIN   = 48'hAAAA_AAD3_9100;
    localparam logic [23:0] ALIGNED_HEAD = 24'hAAD391;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_RECV   = 2'd1,
        ST_HOLD   = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic       found;
        logic [2:0] delay;   // bit slip, 0 = aligned
    } sync_hit_t;

    // Window seen when the stream arrives delayed by d bits.
    function automatic logic [31:0] shifted_pattern(input int unsigned d);
        logic [47:0] t;
        t = SYNC_TRAIN >> d;
        return t[31:0];
    endfunction

    // One byte of the reflected 0x8408 CRC, low bit first.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) begin
            if (r[0]) r = (r >> 1) ^ 16'h8408;
            else      r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/sar_sync_finder.sv
module sar_sync_finder
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       shift,
    input  logic [7:0] din,
    output sync_hit_t  hit
);

    logic [23:0] hist;     // three older raw bytes, oldest in the top
    logic [31:0] cand;
    logic [7:0]  mhit;     // bit 0 = aligned, bit d = slip d

    assign cand    = {hist, din};
    assign mhit[0] = (hist == ALIGNED_HEAD);

    genvar g;
    generate
        for (g = 1; g < 8; g++) begin : g_pat
            localparam logic [31:0] PAT = shifted_pattern(g);
            assign mhit[g] = (cand == PAT);
        end
    endgenerate

    // Lowest slip wins; aligned has top priority.
    always_comb begin
        hit = '0;
        for (int k = 7; k >= 0; k--) begin
            if (mhit[k]) begin
                hit.found = 1'b1;
                hit.delay = 3'(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) hist <= '0;
        else if (shift)   hist <= {hist[15:0], din};
    end

endmodule

// File: rtl/sar_realign.sv
module sar_realign (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [2:0] delay,
    input  logic [7:0] din,
    output logic [7:0] dout
);

    logic [6:0]  prev_low;   // the previous byte's top bit is never needed
    logic [14:0] pair;
    logic [7:0]  cands [8];

    assign pair = {prev_low, din};

    genvar g;
    generate
        for (g = 0; g < 8; g++) begin : g_cand
            if (g == 0) begin : g_zero
                assign cands[g] = pair[7:0];
            end else begin : g_slip
                assign cands[g] = pair[15-g -: 8];
            end
        end
    endgenerate

    assign dout = cands[delay];

    always_ff @(posedge clk) begin
        if (rst)       prev_low <= '0;
        else if (load) prev_low <= din[6:0];
    end

endmodule

// File: rtl/sar_crc16.sv
module sar_crc16
    import sar_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        seed,
    input  logic [15:0] seed_count,
    input  logic        feed,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk) begin
        if (rst)       crc <= 16'hFFFF;
        else if (seed) crc <= crc_step(crc_step(16'hFFFF, seed_count[7:0]), seed_count[15:8]);
        else if (feed) crc <= crc_step(crc, din);
    end

endmodule

// File: rtl/sync_align_rx.sv
module sync_align_rx
    import sar_pkg::*;
#(
    parameter int BUF_DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [7:0]                   in_byte,
    input  logic                         ack,
    output logic                         wr_en,
    output logic [$clog2(BUF_DEPTH)-1:0] wr_idx,
    output logic [7:0]                   wr_data,
    output logic                         rssi_strobe,
    output logic                         pkt_ready,
    output logic                         crc_err
);

    localparam int IDX_W = $clog2(BUF_DEPTH);
    localparam int CNT_W = $clog2(BUF_DEPTH + 1);

    rx_state_e        state;
    logic [CNT_W-1:0] count;
    logic [7:0]       frame_len;
    logic [2:0]       delay;
    logic [7:0]       crc_hi;

    sync_hit_t   hit;
    logic [7:0]  rbyte;
    logic [15:0] crc;

    logic recv_byte, is_len_byte, len_bad, is_last, is_crc_hi, crc_ok;
    logic finder_clear, crc_seed, crc_feed;

    assign recv_byte   = in_valid && (state == ST_RECV);
    assign is_len_byte = (int'(count) == HDR_BYTES - 1);
    assign len_bad     = (int'(rbyte) < MIN_FRAME) || (int'(rbyte) > BUF_DEPTH);
    assign is_last     = (int'(count) >= HDR_BYTES) && (int'(count) + 1 == int'(frame_len));
    assign is_crc_hi   = (int'(count) >= HDR_BYTES) && (int'(count) + 2 == int'(frame_len));
    assign crc_ok      = (crc == {crc_hi, rbyte});

    assign crc_seed     = recv_byte && is_len_byte && !len_bad;
    assign crc_feed     = recv_byte && !is_len_byte && (int'(count) >= HDR_BYTES) && !is_last && !is_crc_hi;
    assign finder_clear = (recv_byte && is_len_byte && len_bad)
                        || (recv_byte && !is_len_byte && is_last && !crc_ok)
                        || (state == ST_HOLD && ack);

    sar_sync_finder u_find (
        .clk   (clk),
        .rst   (rst),
        .clear (finder_clear),
        .shift (in_valid && state == ST_SEARCH),
        .din   (in_byte),
        .hit   (hit)
    );

    sar_realign u_align (
        .clk   (clk),
        .rst   (rst),
        .load  (in_valid && state != ST_HOLD),
        .delay (delay),
        .din   (in_byte),
        .dout  (rbyte)
    );

    sar_crc16 u_crc (
        .clk        (clk),
        .rst        (rst),
        .seed       (crc_seed),
        .seed_count (16'(rbyte) - 16'(CRC_BYTES)),
        .feed       (crc_feed),
        .din        (rbyte),
        .crc        (crc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_SEARCH;
            count       <= '0;
            frame_len   <= '0;
            delay       <= '0;
            crc_hi      <= '0;
            wr_en       <= 1'b0;
            wr_idx      <= '0;
            wr_data     <= '0;
            rssi_strobe <= 1'b0;
            pkt_ready   <= 1'b0;
            crc_err     <= 1'b0;
        end else begin
            wr_en       <= 1'b0;
            rssi_strobe <= 1'b0;
            crc_err     <= 1'b0;
            case (state)
                ST_SEARCH: begin
                    if (in_valid && hit.found) begin
                        rssi_strobe <= 1'b1;
                        state       <= ST_RECV;
                        delay       <= hit.delay;
                        if (hit.delay == 3'd0) begin
                            wr_en   <= 1'b1;
                            wr_idx  <= '0;
                            wr_data <= in_byte;
                            count   <= CNT_W'(1);
                        end else begin
                            count   <= '0;
                        end
                    end
                end
                ST_RECV: begin
                    if (in_valid) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= count[IDX_W-1:0];
                        wr_data <= rbyte;
                        count   <= count + 1'b1;
                        if (is_len_byte) begin
                            frame_len <= rbyte;
                            if (len_bad) state <= ST_SEARCH;
                        end else if (is_last) begin
                            if (crc_ok) begin
                                state     <= ST_HOLD;
                                pkt_ready <= 1'b1;
                            end else begin
                                crc_err <= 1'b1;
                                state   <= ST_SEARCH;
                            end
                        end else if (is_crc_hi) begin
                            crc_hi <= rbyte;
                        end
                    end
                end
                ST_HOLD: begin
                    if (ack) begin
                        pkt_ready <= 1'b0;
                        state     <= ST_SEARCH;
                    end
                end
                default: state <= ST_SEARCH;
            endcase
        end
    end

endmodule

// File: rtl/sync_align_rx_chk.sv
module sync_align_rx_chk #(
    parameter int BUF_DEPTH = 64
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         ack,
    input logic                         wr_en,
    input logic [$clog2(BUF_DEPTH)-1:0] wr_idx,
    input logic                         rssi_strobe,
    input logic                         pkt_ready,
    input logic                         crc_err
);

    assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rssi_strobe |=> !rssi_strobe);

    assert_sync_first_idx_R2: assert property (@(posedge clk) disable iff (rst)
        (rssi_strobe && wr_en) |-> (wr_idx == '0));

    assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < BUF_DEPTH));

    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        crc_err |=> !crc_err);

    assert_err_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> !pkt_ready);

    assert_ready_held_R8: assert property (@(posedge clk) disable iff (rst)
        (pkt_ready && !ack) |=> pkt_ready);

    assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (pkt_ready && $past(pkt_ready)) |-> (!wr_en && !rssi_strobe));

    assert_ack_release_R8: assert property (@(posedge clk) disable iff (rst)
        (pkt_ready && ack) |=> !pkt_ready);

endmodule

bind sync_align_rx sync_align_rx_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ack         (ack),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .rssi_strobe (rssi_strobe),
    .pkt_ready   (pkt_ready),
    .crc_err     (crc_err)
);

// File: tb/sync_align_rx_tb.sv
module sync_align_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int IW         = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = '0;
    logic          ack = 1'b0;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [7:0]    wr_data;
    logic          rssi_strobe;
    logic          pkt_ready;
    logic          crc_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sync_align_rx #(.BUF_DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .ack         (ack),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .rssi_strobe (rssi_strobe),
        .pkt_ready   (pkt_ready),
        .crc_err     (crc_err)
    );

    int nchk = 0;
    int nfail = 0;
    int nwr = 0;
    int nstb = 0;
    int nerr = 0;
    logic [7:0] cap [256];
    logic [7:0] fq[$];
    logic [7:0] raw[$];
    logic [7:0] exp_b[$];

    // Byte-swap form of the reflected CCITT update.
    function automatic logic [15:0] tb_crc(input logic [15:0] a0, input logic [7:0] b);
        logic [15:0] a;
        a = a0 ^ {8'h00, b};
        a = {a[7:0], a[15:8]};
        a = a ^ ((a & 16'hFF00) << 4);
        a = a ^ (a >> 12);
        a = a ^ ((a & 16'hFF00) >> 5);
        return a;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                cap[wr_idx] = wr_data;
                nwr++;
            end
            if (rssi_strobe) nstb++;
            if (crc_err)     nerr++;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    endtask

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, expv);
        end
    endtask

    task automatic clear_mon();
        nwr = 0; nstb = 0; nerr = 0;
        for (int i = 0; i < 256; i++) cap[i] = 8'h00;
    endtask

    // Build a frame with length field lf and np payload bytes, slip d, noise first.
    task automatic build(input int lf, input int np, input bit corrupt, input int d, input int noise);
        logic [15:0] acc;
        logic [15:0] w;
        logic [15:0] pair;
        fq.delete(); raw.delete(); exp_b.delete();
        repeat (4) fq.push_back(8'hAA);
        fq.push_back(8'hD3);
        fq.push_back(8'h91);
        exp_b.push_back(8'h00);
        exp_b.push_back(lf[7:0]);
        w   = 16'(lf - 2);
        acc = tb_crc(16'hFFFF, w[7:0]);
        acc = tb_crc(acc, w[15:8]);
        for (int i = 0; i < np; i++) begin
            logic [7:0] p;
            p = 8'($urandom);
            exp_b.push_back(p);
            acc = tb_crc(acc, p);
        end
        exp_b.push_back(acc[15:8]);
        exp_b.push_back(corrupt ? (acc[7:0] ^ 8'h01) : acc[7:0]);
        foreach (exp_b[i]) fq.push_back(exp_b[i]);
        fq.push_back(8'h55);
        fq.push_back(8'h55);
        for (int i = 0; i < noise; i++) raw.push_back(8'($urandom));
        for (int j = 0; j + 1 < fq.size(); j++) begin
            pair = {fq[j], fq[j+1]} >> d;
            raw.push_back(pair[7:0]);
        end
    endtask

    task automatic send(input bit gaps);
        foreach (raw[i]) begin
            in_valid = 1'b1;
            in_byte  = raw[i];
            @(posedge clk); #1;
            in_valid = 1'b0;
            if (gaps) repeat ($urandom_range(0, 2)) begin @(posedge clk); #1; end
        end
        repeat (3) begin @(posedge clk); #1; end
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(posedge clk); #1;
        ack = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic check_frame(input string tag, input bit good);
        int mis;
        mis = 0;
        for (int i = 0; i < exp_b.size(); i++) if (cap[i] !== exp_b[i]) mis++;
        chk(nstb == 1, tag, "sync strobes", nstb, 1);
        chk(nwr == exp_b.size(), tag, "bytes written", nwr, exp_b.size());
        chk(mis == 0, tag, "byte mismatches", mis, 0);
        chk(pkt_ready == good, tag, "pkt_ready", int'(pkt_ready), int'(good));
        chk(nerr == (good ? 0 : 1), tag, "crc_err pulses", nerr, good ? 0 : 1);
    endtask

    task automatic check_abandon(input string tag, input int lf);
        chk(nstb == 1, tag, "sync strobes", nstb, 1);
        chk(nwr == 2, tag, "bytes written", nwr, 2);
        chk(cap[1] == 8'(lf), tag, "length byte", int'(cap[1]), lf);
        chk(!pkt_ready && nerr == 0, tag, "ready/err", int'(pkt_ready) + nerr, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R1 watchdog act=%0d exp=%0d", 150000, 0);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        // R1: reset state
        chk(!wr_en && !rssi_strobe && !pkt_ready && !crc_err, "R1", "outputs after reset",
            int'(wr_en) + int'(rssi_strobe) + int'(pkt_ready) + int'(crc_err), 0);

        // R10: noise only
        clear_mon();
        raw.delete();
        for (int i = 0; i < 40; i++) raw.push_back(8'($urandom));
        send(1'b0);
        chk(nwr == 0 && nstb == 0, "R10", "activity on noise", nwr + nstb, 0);

        // R2 / R3 / R4 / R6 / R8 across every slip
        for (int d = 0; d < 8; d++) begin
            int np;
            np = d * 3;
            clear_mon();
            build(np + 4, np, 1'b0, d, 5);
            send(d[0]);
            check_frame(d == 0 ? "R2" : "R3", 1'b1);
            clear_mon();
            build(10, 6, 1'b0, (d + 3) % 8, 0);
            send(1'b0);
            chk(nwr == 0 && nstb == 0, "R8", "activity while pending", nwr + nstb, 0);
            chk(pkt_ready == 1'b1, "R8", "ready held", int'(pkt_ready), 1);
            pulse_ack();
            chk(pkt_ready == 1'b0, "R8", "ready after ack", int'(pkt_ready), 0);
        end

        // R7: bad CRC, then a good frame right after
        clear_mon();
        build(9, 5, 1'b1, 5, 2);
        send(1'b0);
        check_frame("R7", 1'b0);
        clear_mon();
        build(7, 3, 1'b0, 2, 0);
        send(1'b0);
        check_frame("R7", 1'b1);
        pulse_ack();

        // R5: illegal lengths
        begin
            int lens [4] = '{0, 3, DEPTH + 1, 200};
            foreach (lens[k]) begin
                clear_mon();
                build(lens[k], 6, 1'b0, (k * 3 + 1) % 8, 1);
                send(1'b0);
                check_abandon("R5", lens[k]);
            end
        end
        // R5: largest legal length
        clear_mon();
        build(DEPTH, DEPTH - 4, 1'b0, 6, 0);
        send(1'b0);
        check_frame("R5", 1'b1);
        pulse_ack();
        // R5: smallest legal length
        clear_mon();
        build(4, 0, 1'b0, 3, 0);
        send(1'b0);
        check_frame("R5", 1'b1);
        pulse_ack();

        // R9: ack while searching has no effect
        pulse_ack();
        clear_mon();
        build(8, 4, 1'b0, 7, 0);
        send(1'b0);
        check_frame("R9", 1'b1);
        pulse_ack();

        // R4 / R6 / R7: random frames
        for (int it = 0; it < 40; it++) begin
            int  d;
            int  np;
            bit  bad;
            d   = $urandom_range(0, 7);
            np  = $urandom_range(0, 20);
            bad = ($urandom_range(0, 3) == 0);
            clear_mon();
            build(np + 4, np, bad, d, $urandom_range(0, 6));
            send(1'b1);
            check_frame(bad ? "R7" : "R4", !bad);
            if (!bad) pulse_ack();
        end

        summary();
        $finish;
    end

endmodule